// File: doc/BRIEF.md
# Configurable UART Character Receiver

This block turns an asynchronous serial line into whole characters. A sampling tick at sixteen times the bit rate paces it. A falling edge on the line starts a character, and the start bit is accepted only if the line is still low at its centre. The data bits, an optional parity bit and the stop bit are then taken at their own centres. Each finished character goes into a single holding register, together with a parity-error flag and a framing-error flag for that character.

The host gives the character format as a small line-control word: a two-bit length code and a three-bit parity code. Odd, even, always-one and always-zero parity are all checked. The host sees a data-available flag and an interrupt, which it may enable or mask. A one-cycle read strobe takes the character. If a character arrives before the previous one has been read, the new one replaces it and an overrun flag is set.

Top module: `uart_char_rx`

## Requirements
- R1: `cfg_len` sets the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Bits arrive least significant first, and the unused upper bits of `rx_char` read as zero.
- R2: `cfg_par` is {stick, even, enable}, so x x 0 means no parity, 001 odd, 011 even, 101 a parity bit of 1 and 111 a parity bit of 0. When parity is enabled, the parity bit comes after the last data bit. `rx_perr` is set with the character when the received parity bit differs from the expected one, and stays 0 when parity is off.
- R3: Only the first stop bit is sampled. `rx_ferr` is set with the character when that bit is 0. Extra stop bits sent by the far end have no effect.
- R4: A falling edge that is high again at the centre of the start bit (tick 8 of 16) is dropped, and no character is produced.
- R5: `rx_avail` becomes 1 one clock after a character completes and stays 1 until `rd_stb`. `irq` is 1 exactly when `rx_avail` and `irq_en` are both 1.
- R6: If a character completes while `rx_avail` is still 1 and no read is made in that cycle, `rx_overrun` becomes 1 and the buffer holds the new character. `rd_stb` clears `rx_overrun`.
- R7: After reset, `rx_avail`, `rx_overrun`, `irq`, `rx_perr`, `rx_ferr` and `rx_char` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| cfg_len | input | 2 | Data length code |
| cfg_par | input | 3 | Parity code {stick, even, enable} |
| irq_en | input | 1 | Interrupt enable |
| rd_stb | input | 1 | Read strobe, takes the buffered character |
| rx_char | output | 8 | Buffered character |
| rx_perr | output | 1 | Parity error of the buffered character |
| rx_ferr | output | 1 | Framing error of the buffered character |
| rx_avail | output | 1 | Character waiting |
| rx_overrun | output | 1 | An unread character was overwritten |
| irq | output | 1 | Data-available interrupt |

## Verification
Characters are sent with every length code and with all-ones and mixed bit patterns. This separates a wrong bit count from wrong bit order, and it shows whether the upper bits are zero-filled. Each parity mode is sent once with a correct parity bit and once with an inverted one, which tells a swapped odd/even decode apart from a swapped stick polarity. A two-stop-bit frame, a frame with a zero stop bit, a short glitch on the line, and two characters sent back to back without a read cover framing, start-bit rejection and overrun.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PAR,
      RX_STOP
   } rx_state_t;

   // Expected parity bit: cfg = {stick, even, enable}
   function automatic logic exp_parity(input logic [2:0] cfg, input logic data_xor);
      if (cfg[2]) return ~cfg[1];
      return cfg[1] ? data_xor : ~data_xor;
   endfunction
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   output logic line_out,
   output logic line_fall
);
   logic line_prev;

   generate
      if (STAGES > 0) begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2+((STAGES>1)?0:1):0], line_in};
         end
         assign line_out = chain[STAGES-1];
      end else begin : g_bypass
         assign line_out = line_in;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_prev <= 1'b1;
      else        line_prev <= line_out;
   end

   assign line_fall = line_prev & ~line_out;
endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
   import uart_rx_pkg::*;
#(
   parameter int DW  = 8,
   parameter int OVS = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          line,
   input  logic          line_fall,
   input  logic [1:0]    cfg_len,
   input  logic [2:0]    cfg_par,
   output logic          done,
   output logic [DW-1:0] dout,
   output logic          perr,
   output logic          ferr
);
   localparam int CW   = $clog2(OVS);
   localparam int IW   = $clog2(DW + 1);
   localparam int MINW = DW - 3;
   localparam logic [CW-1:0] MID  = CW'(OVS/2 - 1);
   localparam logic [CW-1:0] FULL = CW'(OVS - 1);

   rx_state_t     state;
   logic [CW-1:0] cnt;
   logic [IW-1:0] idx;
   logic [IW-1:0] nbits;
   logic [DW-1:0] shreg;
   logic          pbit;

   assign nbits = IW'(MINW) + IW'(cfg_len);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= RX_IDLE;
         cnt   <= '0;
         idx   <= '0;
         shreg <= '0;
         pbit  <= 1'b0;
         done  <= 1'b0;
         dout  <= '0;
         perr  <= 1'b0;
         ferr  <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            RX_IDLE: if (line_fall) begin
               state <= RX_START;
               cnt   <= '0;
            end
            RX_START: if (tick) begin
               if (cnt == MID) begin
                  cnt <= '0;
                  if (line) state <= RX_IDLE;
                  else begin
                     state <= RX_DATA;
                     idx   <= '0;
                     shreg <= '0;
                  end
               end else cnt <= cnt + 1'b1;
            end
            RX_DATA: if (tick) begin
               if (cnt == FULL) begin
                  cnt        <= '0;
                  shreg[idx] <= line;
                  idx        <= idx + 1'b1;
                  if (idx == nbits - 1'b1) state <= cfg_par[0] ? RX_PAR : RX_STOP;
               end else cnt <= cnt + 1'b1;
            end
            RX_PAR: if (tick) begin
               if (cnt == FULL) begin
                  cnt   <= '0;
                  pbit  <= line;
                  state <= RX_STOP;
               end else cnt <= cnt + 1'b1;
            end
            RX_STOP: if (tick) begin
               if (cnt == FULL) begin
                  cnt   <= '0;
                  done  <= 1'b1;
                  dout  <= shreg;
                  perr  <= cfg_par[0] & (pbit != exp_parity(cfg_par, ^shreg));
                  ferr  <= ~line;
                  state <= RX_IDLE;
               end else cnt <= cnt + 1'b1;
            end
            default: state <= RX_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/uart_rx_holding.sv
module uart_rx_holding #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] din,
   input  logic          pin,
   input  logic          fin,
   input  logic          rd_stb,
   input  logic          irq_en,
   output logic [DW-1:0] rbr,
   output logic          perr,
   output logic          ferr,
   output logic          avail,
   output logic          overrun,
   output logic          irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbr     <= '0;
         perr    <= 1'b0;
         ferr    <= 1'b0;
         avail   <= 1'b0;
         overrun <= 1'b0;
      end else begin
         if (load) begin
            rbr   <= din;
            perr  <= pin;
            ferr  <= fin;
            avail <= 1'b1;
            if (avail && !rd_stb) overrun <= 1'b1;
            else if (rd_stb)      overrun <= 1'b0;
         end else if (rd_stb) begin
            avail   <= 1'b0;
            overrun <= 1'b0;
         end
      end
   end

   assign irq = avail & irq_en;
endmodule

// File: rtl/uart_char_rx.sv
module uart_char_rx #(
   parameter int DW          = 8,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick16,
   input  logic          rxd,
   input  logic [1:0]    cfg_len,
   input  logic [2:0]    cfg_par,
   input  logic          irq_en,
   input  logic          rd_stb,
   output logic [DW-1:0] rx_char,
   output logic          rx_perr,
   output logic          rx_ferr,
   output logic          rx_avail,
   output logic          rx_overrun,
   output logic          irq
);
   generate
      if (DW < 4)                   begin : g_bad_dw   $error("DW must be at least 4"); end
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs  $error("OVS must be even and at least 4"); end
      if (SYNC_STAGES < 0)          begin : g_bad_sync $error("SYNC_STAGES must not be negative"); end
   endgenerate

   logic          line_s, line_fall;
   logic          rx_done;
   logic [DW-1:0] eng_data;
   logic          eng_perr, eng_ferr;

   uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .line_in(rxd),
      .line_out(line_s), .line_fall(line_fall)
   );

   uart_rx_engine #(.DW(DW), .OVS(OVS)) u_eng (
      .clk(clk), .rst_n(rst_n), .tick(tick16), .line(line_s), .line_fall(line_fall),
      .cfg_len(cfg_len), .cfg_par(cfg_par),
      .done(rx_done), .dout(eng_data), .perr(eng_perr), .ferr(eng_ferr)
   );

   uart_rx_holding #(.DW(DW)) u_hold (
      .clk(clk), .rst_n(rst_n), .load(rx_done), .din(eng_data),
      .pin(eng_perr), .fin(eng_ferr), .rd_stb(rd_stb), .irq_en(irq_en),
      .rbr(rx_char), .perr(rx_perr), .ferr(rx_ferr),
      .avail(rx_avail), .overrun(rx_overrun), .irq(irq)
   );
endmodule

// File: rtl/uart_char_rx_chk.sv
module uart_char_rx_chk #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rd_stb,
   input logic          done,
   input logic [1:0]    cfg_len,
   input logic [2:0]    cfg_par,
   input logic [DW-1:0] rx_char,
   input logic          rx_perr,
   input logic          rx_avail,
   input logic          rx_overrun
);
   assert_avail_drop_needs_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_avail) |-> $past(rd_stb));

   assert_avail_after_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> rx_avail);

   assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !done) |=> !rx_avail);

   assert_overrun_needs_unread_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_overrun) |-> ($past(rx_avail) && !$past(rd_stb)));

   assert_short_word_zero_fill_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rx_avail) && $past(cfg_len) == 2'b00) |-> ((rx_char >> (DW-3)) == '0));

   assert_no_perr_without_parity_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rx_avail) && !$past(cfg_par[0])) |-> !rx_perr);
endmodule

bind uart_char_rx uart_char_rx_chk #(.DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .done(rx_done),
   .cfg_len(cfg_len), .cfg_par(cfg_par), .rx_char(rx_char),
   .rx_perr(rx_perr), .rx_avail(rx_avail), .rx_overrun(rx_overrun)
);

// File: tb/tb_uart_char_rx.sv
`timescale 1ns/1ps
module tb_uart_char_rx;
   localparam int TICKDIV = 4;
   localparam int BITCLK  = 16 * TICKDIV;

   typedef struct packed {
      logic [7:0] d;
      logic       pe;
      logic       fe;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick16 = 1'b0;
   logic       rxd = 1'b1;
   logic [1:0] cfg_len = 2'b11;
   logic [2:0] cfg_par = 3'b000;
   logic       irq_en = 1'b1;
   logic       auto_rd = 1'b1;
   logic       mon_rd = 1'b0;
   logic       man_rd = 1'b0;
   logic       rd_stb;
   logic [7:0] rx_char;
   logic       rx_perr, rx_ferr, rx_avail, rx_overrun, irq;

   int   tests = 0;
   int   fails = 0;
   int   tcnt  = 0;
   exp_t q[$];

   assign rd_stb = mon_rd | man_rd;

   always #10 clk = ~clk;

   always @(negedge clk) begin
      tcnt   <= (tcnt == TICKDIV-1) ? 0 : tcnt + 1;
      tick16 <= (tcnt == TICKDIV-1);
   end

   uart_char_rx dut (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
      .cfg_len(cfg_len), .cfg_par(cfg_par), .irq_en(irq_en), .rd_stb(rd_stb),
      .rx_char(rx_char), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
      .rx_avail(rx_avail), .rx_overrun(rx_overrun), .irq(irq)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Monitor: pops the scoreboard when a character appears and reads it
   always @(negedge clk) begin
      if (auto_rd && rx_avail && !mon_rd) begin
         if (q.size() == 0) begin
            check("R4", "unexpected character", 1, 0);
         end else begin
            exp_t e;
            e = q.pop_front();
            check("R1", "character", int'(rx_char), int'(e.d));
            check("R2", "parity error", int'(rx_perr), int'(e.pe));
            check("R3", "framing error", int'(rx_ferr), int'(e.fe));
            check("R6", "overrun", int'(rx_overrun), 0);
            check("R5", "irq", int'(irq), int'(irq_en));
         end
         mon_rd <= 1'b1;
      end else begin
         mon_rd <= 1'b0;
      end
   end

   task automatic bit_time(input logic v);
      rxd = v;
      repeat (BITCLK) @(negedge clk);
   endtask

   // Driver: sends one frame with the current configuration
   task automatic send(input logic [7:0] d, input bit bad_par, input bit bad_stop,
                       input int nstop, input bit push);
      int         nb;
      logic [7:0] m;
      logic       pb;
      nb = 5 + int'(cfg_len);
      m  = d & 8'((1 << nb) - 1);
      if (cfg_par[2]) pb = ~cfg_par[1];
      else            pb = cfg_par[1] ? ($countones(m) % 2 == 1) : ($countones(m) % 2 == 0);
      if (bad_par) pb = ~pb;
      if (push) q.push_back('{d: m, pe: bad_par && cfg_par[0], fe: bad_stop});
      bit_time(1'b0);
      for (int i = 0; i < nb; i++) bit_time(d[i]);
      if (cfg_par[0]) bit_time(pb);
      bit_time(~bad_stop);
      for (int i = 1; i < nstop; i++) bit_time(1'b1);
      bit_time(1'b1);
      bit_time(1'b1);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      check("R7", "avail after reset", int'(rx_avail), 0);
      check("R7", "irq after reset", int'(irq), 0);
      check("R7", "overrun after reset", int'(rx_overrun), 0);
      check("R7", "char after reset", int'(rx_char), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R1: lengths and bit order
      cfg_len = 2'b11; send(8'hA5, 0, 0, 1, 1);
      send(8'h3C, 0, 0, 1, 1);
      cfg_len = 2'b00; send(8'hFF, 0, 0, 1, 1);
      cfg_len = 2'b01; send(8'hEA, 0, 0, 1, 1);
      cfg_len = 2'b10; send(8'hD3, 0, 0, 1, 1);

      // R2: parity modes, good and bad
      cfg_len = 2'b11;
      cfg_par = 3'b001; send(8'h5B, 0, 0, 1, 1); send(8'h5B, 1, 0, 1, 1);
      cfg_par = 3'b011; send(8'h5B, 0, 0, 1, 1); send(8'h81, 1, 0, 1, 1);
      cfg_par = 3'b101; send(8'h07, 0, 0, 1, 1); send(8'h07, 1, 0, 1, 1);
      cfg_par = 3'b111; send(8'h07, 0, 0, 1, 1); send(8'h07, 1, 0, 1, 1);
      cfg_len = 2'b00; cfg_par = 3'b011; send(8'h13, 0, 0, 1, 1);

      // R3: two stop bits, bad first stop bit
      cfg_len = 2'b11; cfg_par = 3'b000;
      send(8'h96, 0, 0, 2, 1);
      send(8'h69, 0, 1, 1, 1);
      cfg_par = 3'b001; send(8'h42, 1, 1, 1, 1);
      cfg_par = 3'b000;

      // R5: masked interrupt
      irq_en = 1'b0; send(8'h55, 0, 0, 1, 1); irq_en = 1'b1;

      // R4: glitch shorter than half a bit
      rxd = 1'b0; repeat (3 * TICKDIV) @(negedge clk);
      rxd = 1'b1; repeat (3 * BITCLK) @(negedge clk);
      check("R4", "avail after glitch", int'(rx_avail), 0);
      send(8'hC3, 0, 0, 1, 1);
      check("R1", "scoreboard drained", q.size(), 0);

      // R6: overrun
      auto_rd = 1'b0;
      send(8'h11, 0, 0, 1, 0);
      check("R5", "avail held without read", int'(rx_avail), 1);
      check("R6", "no overrun after one", int'(rx_overrun), 0);
      send(8'h22, 0, 0, 1, 0);
      check("R6", "overrun set", int'(rx_overrun), 1);
      check("R6", "newer char kept", int'(rx_char), 8'h22);
      man_rd = 1'b1; @(negedge clk); man_rd = 1'b0; @(negedge clk);
      check("R5", "avail cleared by read", int'(rx_avail), 0);
      check("R6", "overrun cleared by read", int'(rx_overrun), 0);
      check("R5", "irq cleared by read", int'(irq), 0);
      auto_rd = 1'b1;

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule